// File: doc/BRIEF.md
# Exception Entry and Status Save Unit

This block handles the status bookkeeping when a processor takes an exception and when it returns from one. Seven request lines can raise an exception: reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ. On each clock edge the unit drops any interrupt request whose disable bit is set and picks the highest-priority request that remains. It then emits a one-cycle vector pulse that carries the handler address. It also switches the mode field of the live status word, sets the interrupt-disable bits, and saves the previous status word in the saved-status register of the mode it enters.

Every exception-handling mode (FIQ, IRQ, Supervisor, Abort, Undefined) has its own saved-status register. User and System modes have none. A return strobe copies the saved word of the current mode back into the status word, so execution resumes in the interrupted mode. A return raised from User or System mode changes nothing and pulses an error output. The core can also load the status word directly through a write port.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the status word is 0x000000D3: Supervisor mode, IRQ-disable (bit 7) set, FIQ-disable (bit 6) set. The vector pulse and the error pulse are low, and every saved-status register reads zero.
- R2: When an exception is taken, `vec_valid_o` is high for the cycle after the taking edge. `vec_addr_o` is then the vector base (zero by default) plus the offset for that kind: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. Offset 0x14 never appears.
- R3: When several unmasked requests arrive together, exactly one is served. The order from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. The request bits are reset=0, undefined=1, software interrupt=2, prefetch abort=3, data abort=4, IRQ=5, FIQ=6.
- R4: Entry writes the mode field (bits 4:0) with 0x13 (Supervisor) for reset and software interrupt, 0x17 (Abort) for both aborts, 0x1B for undefined, 0x12 for IRQ and 0x11 for FIQ. The other mode encodings are User 0x10 and System 0x1F.
- R5: Every entry sets bit 7. Reset and FIQ entries also set bit 6. All other status bits keep their previous values.
- R6: Entry copies the status word held before that edge into the saved-status register of the mode being entered. `saved_o` always shows the saved-status register of the current mode, or zero in User and System mode.
- R7: Each exception mode's saved-status register is written only on entry to that mode. Nested entries into other modes leave it intact.
- R8: A return strobe with no exception taken, issued in an exception mode, loads the status word from that mode's saved-status register. It raises no vector pulse.
- R9: A return issued in User or System mode leaves the status word unchanged and raises `ret_err_o` for one cycle.
- R10: An IRQ request while bit 7 is set, or an FIQ request while bit 6 is set, is ignored: no vector pulse and no status change.
- R11: In one cycle, a taken exception wins over a return and over a status write, and a return wins over a status write.
- R12: With no exception and no return, `wr_en_i` loads `wr_data_i` into the status word at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 7 | Exception request lines, bit map as in R3 |
| ret_i | input | 1 | Exception-return strobe |
| wr_en_i | input | 1 | Status word write enable |
| wr_data_i | input | 32 | Status word write data |
| status_o | output | 32 | Live status word |
| saved_o | output | 32 | Saved-status register of the current mode |
| vec_valid_o | output | 1 | Vector pulse, one cycle per taken exception |
| vec_addr_o | output | 32 | Handler vector address |
| ret_err_o | output | 1 | Pulse for a return issued without a saved copy |

## Verification
The assertions assume that the mode field of the status word always holds one of the seven defined encodings. An undefined encoding has no saved-status register, and its return behaviour is not a requirement. The stimulus respects this: every status write draws its mode field from the seven legal codes, and only the flag, mask and state bits are random. Requests, returns and writes otherwise arrive freely and often overlap in the same cycle, so the arbitration and the masking rules see many combinations.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int N_KIND  = 7;
   localparam int KIND_W  = 3;
   localparam int N_BANK  = 5;
   localparam int BANK_W  = 3;
   localparam int MODE_W  = 5;

   // request bit positions
   localparam int K_RST  = 0;
   localparam int K_UND  = 1;
   localparam int K_SWI  = 2;
   localparam int K_PABT = 3;
   localparam int K_DABT = 4;
   localparam int K_IRQ  = 5;
   localparam int K_FIQ  = 6;

   // status word bit positions
   localparam int SB_FDIS = 6;
   localparam int SB_IDIS = 7;

   localparam logic [MODE_W-1:0] M_USR = 5'h10;
   localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
   localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
   localparam logic [MODE_W-1:0] M_SVC = 5'h13;
   localparam logic [MODE_W-1:0] M_ABT = 5'h17;
   localparam logic [MODE_W-1:0] M_UND = 5'h1B;
   localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

   typedef struct packed {
      logic              valid;
      logic [BANK_W-1:0] idx;
   } bank_sel_t;

   // rank 0 is served first
   function automatic logic [KIND_W-1:0] prio_kind(input int rank);
      case (rank)
         0:       return KIND_W'(K_RST);
         1:       return KIND_W'(K_DABT);
         2:       return KIND_W'(K_FIQ);
         3:       return KIND_W'(K_IRQ);
         4:       return KIND_W'(K_PABT);
         5:       return KIND_W'(K_UND);
         default: return KIND_W'(K_SWI);
      endcase
   endfunction

   function automatic logic [MODE_W-1:0] kind_mode(input logic [KIND_W-1:0] k);
      case (k)
         KIND_W'(K_RST), KIND_W'(K_SWI):   return M_SVC;
         KIND_W'(K_PABT), KIND_W'(K_DABT): return M_ABT;
         KIND_W'(K_UND):                   return M_UND;
         KIND_W'(K_IRQ):                   return M_IRQ;
         default:                          return M_FIQ;
      endcase
   endfunction

   // byte offset; slot 0x14 is skipped on purpose
   function automatic logic [4:0] kind_offset(input logic [KIND_W-1:0] k);
      case (k)
         KIND_W'(K_IRQ): return 5'h18;
         KIND_W'(K_FIQ): return 5'h1C;
         default:        return {k, 2'b00};
      endcase
   endfunction

   function automatic bank_sel_t mode_bank(input logic [MODE_W-1:0] m);
      bank_sel_t s;
      s.valid = 1'b1;
      case (m)
         M_FIQ:   s.idx = 3'd0;
         M_IRQ:   s.idx = 3'd1;
         M_SVC:   s.idx = 3'd2;
         M_ABT:   s.idx = 3'd3;
         M_UND:   s.idx = 3'd4;
         default: begin s.valid = 1'b0; s.idx = 3'd0; end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int N_REQ = N_KIND
) (
   input  logic [N_REQ-1:0]  req_i,
   input  logic              irq_dis_i,
   input  logic              fiq_dis_i,
   output logic              take_o,
   output logic [KIND_W-1:0] kind_o
);

   if (N_REQ != N_KIND) begin : g_bad_nreq
      $error("exc_arbiter: N_REQ must equal the number of exception kinds");
   end

   logic [N_REQ-1:0] eff;

   for (genvar i = 0; i < N_REQ; i++) begin : g_mask
      if (i == K_IRQ) begin : g_irq
         assign eff[i] = req_i[i] & ~irq_dis_i;
      end else if (i == K_FIQ) begin : g_fiq
         assign eff[i] = req_i[i] & ~fiq_dis_i;
      end else begin : g_plain
         assign eff[i] = req_i[i];
      end
   end

   always_comb begin
      take_o = 1'b0;
      kind_o = '0;
      for (int r = N_REQ - 1; r >= 0; r--) begin
         if (eff[prio_kind(r)]) begin
            take_o = 1'b1;
            kind_o = prio_kind(r);
         end
      end
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter bit          HIGH_VEC  = 1'b0,
   parameter int unsigned HIGH_BASE = 32'hFFFF_0000
) (
   input  logic [KIND_W-1:0] kind_i,
   output logic [ADDR_W-1:0] addr_o
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("exc_vector_gen: ADDR_W too small for the vector table");
   end

   logic [ADDR_W-1:0] base;

   if (HIGH_VEC) begin : g_high
      assign base = ADDR_W'(HIGH_BASE);
   end else begin : g_low
      assign base = '0;
   end

   assign addr_o = base + ADDR_W'(kind_offset(kind_i));

endmodule

// File: rtl/exc_saved_bank.sv
module exc_saved_bank
   import exc_pkg::*;
#(
   parameter int STAT_W = 32,
   parameter int NB     = N_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [BANK_W-1:0] wsel_i,
   input  logic [STAT_W-1:0] wdata_i,
   input  logic [BANK_W-1:0] rsel_i,
   output logic [STAT_W-1:0] rdata_o
);

   if (NB > (1 << BANK_W)) begin : g_bad_nb
      $error("exc_saved_bank: NB exceeds the select width");
   end

   logic [STAT_W-1:0] regs [NB];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[b] <= '0;
         else if (we_i && (wsel_i == BANK_W'(b)))
            regs[b] <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < NB; b++)
         if (rsel_i == BANK_W'(b)) rdata_o = regs[b];
   end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_pkg::*;
#(
   parameter int          STAT_W     = 32,
   parameter int          ADDR_W     = 32,
   parameter bit          HIGH_VEC   = 1'b0,
   parameter int unsigned HIGH_BASE  = 32'hFFFF_0000,
   parameter logic [31:0] RST_STATUS = 32'h0000_00D3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_KIND-1:0] req_i,
   input  logic              ret_i,
   input  logic              wr_en_i,
   input  logic [STAT_W-1:0] wr_data_i,
   output logic [STAT_W-1:0] status_o,
   output logic [STAT_W-1:0] saved_o,
   output logic              vec_valid_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic              ret_err_o
);

   localparam int MIN_STAT_W = SB_IDIS + 1;

   if (STAT_W < MIN_STAT_W) begin : g_bad_stat
      $error("exc_entry_unit: STAT_W cannot hold mode and mask bits");
   end

   logic [STAT_W-1:0] status_q, status_n, entry_status, bank_rdata;
   logic              take;
   logic [KIND_W-1:0] kind;
   logic [MODE_W-1:0] cur_mode, tgt_mode;
   bank_sel_t         cur_bank, tgt_bank;
   logic              bank_we, err_n;
   logic [ADDR_W-1:0] vec_addr_n;

   assign cur_mode = status_q[MODE_W-1:0];
   assign cur_bank = mode_bank(cur_mode);

   exc_arbiter #(.N_REQ(N_KIND)) u_arb (
      .req_i     (req_i),
      .irq_dis_i (status_q[SB_IDIS]),
      .fiq_dis_i (status_q[SB_FDIS]),
      .take_o    (take),
      .kind_o    (kind)
   );

   exc_vector_gen #(
      .ADDR_W    (ADDR_W),
      .HIGH_VEC  (HIGH_VEC),
      .HIGH_BASE (HIGH_BASE)
   ) u_vec (
      .kind_i (kind),
      .addr_o (vec_addr_n)
   );

   assign tgt_mode = kind_mode(kind);
   assign tgt_bank = mode_bank(tgt_mode);

   always_comb begin
      entry_status                 = status_q;
      entry_status[MODE_W-1:0]     = tgt_mode;
      entry_status[SB_IDIS]        = 1'b1;
      if (kind == KIND_W'(K_RST) || kind == KIND_W'(K_FIQ))
         entry_status[SB_FDIS] = 1'b1;
   end

   exc_saved_bank #(.STAT_W(STAT_W), .NB(N_BANK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bank_we),
      .wsel_i  (tgt_bank.idx),
      .wdata_i (status_q),
      .rsel_i  (cur_bank.idx),
      .rdata_o (bank_rdata)
   );

   always_comb begin
      status_n = status_q;
      bank_we  = 1'b0;
      err_n    = 1'b0;
      if (take) begin
         status_n = entry_status;
         bank_we  = tgt_bank.valid;
      end else if (ret_i) begin
         if (cur_bank.valid) status_n = bank_rdata;
         else                err_n    = 1'b1;
      end else if (wr_en_i) begin
         status_n = wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q    <= STAT_W'(RST_STATUS);
         vec_valid_o <= 1'b0;
         vec_addr_o  <= '0;
         ret_err_o   <= 1'b0;
      end else begin
         status_q    <= status_n;
         vec_valid_o <= take;
         if (take) vec_addr_o <= vec_addr_n;
         ret_err_o   <= err_n;
      end
   end

   assign status_o = status_q;
   assign saved_o  = cur_bank.valid ? bank_rdata : '0;

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
   import exc_pkg::*;
#(
   parameter int          STAT_W    = 32,
   parameter int          ADDR_W    = 32,
   parameter bit          HIGH_VEC  = 1'b0,
   parameter int unsigned HIGH_BASE = 32'hFFFF_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_KIND-1:0] req_i,
   input logic              ret_i,
   input logic [STAT_W-1:0] status_o,
   input logic [STAT_W-1:0] saved_o,
   input logic              vec_valid_o,
   input logic [ADDR_W-1:0] vec_addr_o,
   input logic              ret_err_o
);

   localparam logic [ADDR_W-1:0] BASE = HIGH_VEC ? ADDR_W'(HIGH_BASE) : '0;

   // R2: the reserved slot never leaves the block
   p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> vec_addr_o != BASE + ADDR_W'(5'h14));

   // R5: every entry leaves IRQ disabled
   p_irq_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> status_o[SB_IDIS]);

   // R5: FIQ vector implies FIQ disabled
   p_fiq_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && vec_addr_o == BASE + ADDR_W'(5'h1C)) |-> status_o[SB_FDIS]);

   // R4: reset request always ends in Supervisor mode
   p_reset_svc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[K_RST] |=> status_o[MODE_W-1:0] == M_SVC);

   // R6: saved copy of the entered mode is the previous status
   p_saved_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> saved_o == $past(status_o));

   // R9: error pulse follows a return and freezes the status
   p_err_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ret_err_o |-> ($past(ret_i) && status_o == $past(status_o)));

   // R9: error only in modes without a saved copy
   p_err_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ret_err_o |-> (status_o[MODE_W-1:0] == M_USR || status_o[MODE_W-1:0] == M_SYS));

   // R10: a lone masked IRQ is not taken
   p_masked_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == N_KIND'(1 << K_IRQ) && status_o[SB_IDIS]) |=> !vec_valid_o);

endmodule

bind exc_entry_unit exc_entry_checker #(
   .STAT_W    (STAT_W),
   .ADDR_W    (ADDR_W),
   .HIGH_VEC  (HIGH_VEC),
   .HIGH_BASE (HIGH_BASE)
) u_exc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .ret_i       (ret_i),
   .status_o    (status_o),
   .saved_o     (saved_o),
   .vec_valid_o (vec_valid_o),
   .vec_addr_o  (vec_addr_o),
   .ret_err_o   (ret_err_o)
);

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  req = '0;
   logic        ret = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] status_o, saved_o, vec_addr_o;
   logic        vec_valid_o, ret_err_o;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   // reference state
   logic [31:0] m_status;
   logic [31:0] m_bank [5];
   logic        m_vec;
   logic [31:0] m_addr;
   logic        m_err;

   always #5 clk = ~clk;

   exc_entry_unit u_exc_entry_unit (
      .clk(clk), .rst_n(rst_n), .req_i(req), .ret_i(ret),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .status_o(status_o),
      .saved_o(saved_o), .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
      .ret_err_o(ret_err_o)
   );

   function automatic int bank_of(input logic [4:0] m);
      case (m)
         5'h11: return 0;
         5'h12: return 1;
         5'h13: return 2;
         5'h17: return 3;
         5'h1B: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic logic [4:0] mode_for(input int k);
      case (k)
         0, 2: return 5'h13;
         3, 4: return 5'h17;
         1: return 5'h1B;
         5: return 5'h12;
         default: return 5'h11;
      endcase
   endfunction

   function automatic logic [31:0] vec_for(input int k);
      case (k)
         5: return 32'h18;
         6: return 32'h1C;
         default: return 32'(k * 4);
      endcase
   endfunction

   // served kind or -1
   function automatic int pick(input logic [6:0] r, input logic [31:0] st);
      int order [7] = '{0, 4, 6, 5, 3, 1, 2};
      logic [6:0] e = r;
      if (st[7]) e[5] = 1'b0;
      if (st[6]) e[6] = 1'b0;
      foreach (order[i]) if (e[order[i]]) return order[i];
      return -1;
   endfunction

   function automatic logic [31:0] legal_word();
      logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
      logic [31:0] w = $urandom;
      w[4:0] = modes[$urandom_range(6)];
      return w;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      int b = bank_of(m_status[4:0]);
      logic [31:0] es = (b < 0) ? 32'h0 : m_bank[b];
      check(status_o == m_status, tag, "status", status_o, m_status);
      check(saved_o == es, tag, "saved", saved_o, es);
      check(vec_valid_o == m_vec, tag, "vec_valid", 32'(vec_valid_o), 32'(m_vec));
      if (m_vec) check(vec_addr_o == m_addr, tag, "vec_addr", vec_addr_o, m_addr);
      check(ret_err_o == m_err, tag, "ret_err", 32'(ret_err_o), 32'(m_err));
   endtask

   // one cycle: drive, advance reference, compare after the edge
   task automatic step(input logic [6:0] r, input bit rt, input bit we,
                       input logic [31:0] wd, input string tag);
      int k;
      int b;
      @(negedge clk);
      req = r; ret = rt; wr_en = we; wr_data = wd;
      k = pick(r, m_status);
      m_vec = 1'b0; m_err = 1'b0;
      if (k >= 0) begin
         m_bank[bank_of(mode_for(k))] = m_status;
         m_status[4:0] = mode_for(k);
         m_status[7] = 1'b1;
         if (k == 0 || k == 6) m_status[6] = 1'b1;
         m_vec = 1'b1;
         m_addr = vec_for(k);
      end else if (rt) begin
         b = bank_of(m_status[4:0]);
         if (b >= 0) m_status = m_bank[b];
         else m_err = 1'b1;
      end else if (we) begin
         m_status = wd;
      end
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   task automatic idle(); step('0, 1'b0, 1'b0, '0, "R10"); endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250125));
      m_status = 32'h0000_00D3;
      foreach (m_bank[i]) m_bank[i] = '0;
      m_vec = 0; m_err = 0; m_addr = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      compare("R1");

      // R12: status write, clear masks, user mode
      step('0, 0, 1, 32'hF000_0010, "R12");
      // R3: all requests, reset wins
      step(7'h7F, 0, 0, '0, "R3");
      step('0, 0, 1, 32'h0000_0010, "R12");
      // R3: FIQ beats IRQ, prefetch abort, undefined, software interrupt
      step(7'b1101110, 0, 0, '0, "R3");
      step('0, 0, 1, 32'h0000_001F, "R12");
      // R3: data abort beats FIQ
      step(7'b1010000, 0, 0, '0, "R3");
      // R7: nested entries preserve earlier banks
      step('0, 0, 1, 32'h3000_0010, "R12");
      step(7'b0100000, 0, 0, '0, "R4");   // IRQ from user
      step(7'b0000010, 0, 0, '0, "R7");   // undefined on top
      step('0, 1, 0, '0, "R8");           // back to IRQ mode
      step('0, 1, 0, '0, "R7");           // back to user
      // R9: return in user and system
      step('0, 1, 0, '0, "R9");
      step('0, 0, 1, 32'h0000_001F, "R12");
      step('0, 1, 0, '0, "R9");
      idle();
      // R10: masked IRQ and FIQ
      step('0, 0, 1, 32'h0000_00D0, "R12");
      step(7'b0100000, 0, 0, '0, "R10");
      step(7'b1000000, 0, 0, '0, "R10");
      step(7'b1100000, 1, 1, 32'h0000_0010, "R10");
      // R11: exception beats return and write
      step(7'b0000100, 1, 1, 32'h0000_0010, "R11");
      step('0, 1, 1, 32'h0000_001F, "R11");
      // R5/R6: FIQ entry from cleared masks
      step('0, 0, 1, 32'h0000_0012, "R12");
      step(7'b1000000, 0, 0, '0, "R5");
      step('0, 1, 0, '0, "R6");
      // R2: each vector individually from System with masks clear
      for (int k = 0; k < 7; k++) begin
         step('0, 0, 1, 32'h0000_001F, "R12");
         step(7'(1 << k), 0, 0, '0, "R2");
      end

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [6:0] r = '0;
         bit rt = ($urandom_range(3) == 0);
         bit we = ($urandom_range(3) == 0);
         for (int j = 1; j < 7; j++) r[j] = ($urandom_range(9) == 0);
         r[0] = ($urandom_range(99) == 0);
         step(r, rt, we, legal_word(),
              (pick(r, m_status) >= 0) ? "R4" : (rt ? "R8" : (we ? "R12" : "R10")));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule